// File: doc/BRIEF.md
# Supply-fault reset sequencer

This block is the digital half of a microcontroller's supply supervisor. Two comparator flags arrive asynchronously. One says the core supply is above the fixed power-on threshold. The other says it is above a selectable brownout threshold. Each flag is synchronised and then glitch-filtered. A four-state sequencer turns the filtered flags into an active-low system reset. It also drives a flag that tells the rest of the chip which class of reset values to load, and a program-fetch address with a one-cycle load strobe at the moment reset is released.

The block tells a full power-on event apart from a brownout. A power-on event happens when the supply falls below the power-on threshold, or when the fabric reset is applied. Release after it waits for a parameterised power-up count. A brownout happens when the supply dips below the brownout threshold but stays above the power-on threshold. Release after it happens as soon as the filtered flag recovers. A two-bit threshold-select register drives the analog comparator. It keeps its value through a brownout, and it returns to 00b on any power-on event. Software may write it only while the core is running.

Top module: `supply_reset_seq`

## Requirements
- R1: After the synchronous reset input is applied, `sys_rst_n_o` is 0, `rst_kind_o` is 0 (power-on), `bor_level_o` is 00b, `fetch_load_o` is 0 and `fetch_addr_o` is 8000h.
- R2: While the filtered brownout flag is low, `sys_rst_n_o` stays 0.
- R3: After a power-on event, `sys_rst_n_o` rises exactly SYNC_STAGES+FILT_LEN+1+PU_CYCLES clock edges after both comparator flags go high together.
- R4: After a brownout without a power-on event, `sys_rst_n_o` rises exactly SYNC_STAGES+FILT_LEN+1 edges after the brownout flag returns high, with no power-up count.
- R5: When the filtered power-on flag goes low, from any state, the block enters the power-on hold: `sys_rst_n_o` is 0, `rst_kind_o` is 0 and `bor_level_o` is cleared to 00b.
- R6: The threshold-select value in `bor_level_o` is unchanged by a brownout hold and its recovery.
- R7: A write (`lvl_wr_en_i` high, value on `lvl_wr_data_i`) updates `bor_level_o` one edge later only while the sequencer is running. While reset is asserted, writes leave `bor_level_o` unchanged.
- R8: On each release, `fetch_load_o` is 1 for exactly the first cycle in which `sys_rst_n_o` is 1, and `fetch_addr_o` then reads 8000h.
- R9: `rst_kind_o` reads 1 after a brownout entry from the running state. It reads 0 after any power-on event, and it keeps that value through the release that follows.
- R10: A comparator flag change that lasts fewer than FILT_LEN consecutive cycles has no effect on `sys_rst_n_o`. A change that lasts FILT_LEN cycles or more is accepted.
- R11: If the brownout flag drops during the power-up count, the count restarts, and release takes the full R3 delay measured from the flag's recovery.
- R12: Once running, `sys_rst_n_o` falls exactly SYNC_STAGES+FILT_LEN+1 edges after the brownout flag goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high fabric reset, treated as a power-on event |
| above_por_i | input | 1 | Asynchronous comparator flag: supply above the power-on threshold |
| above_bor_i | input | 1 | Asynchronous comparator flag: supply above the selected brownout threshold |
| lvl_wr_en_i | input | 1 | Write strobe for the threshold-select register |
| lvl_wr_data_i | input | LVL_W | Value to write to the threshold-select register |
| bor_level_o | output | LVL_W | Threshold-select value sent to the comparator |
| sys_rst_n_o | output | 1 | Active-low system reset |
| rst_kind_o | output | 1 | Reset class: 0 power-on values, 1 brownout values |
| fetch_load_o | output | 1 | One-cycle strobe on reset release |
| fetch_addr_o | output | ADDR_W | Fetch address to load on release (8000h) |

## Verification
The bench builds the block with PU_CYCLES=16, SYNC_STAGES=2 and FILT_LEN=3. With these values a full power-up release takes 22 edges, so its exact edge can be checked on both sides next to the 6-edge brownout release. The bench sweeps glitch widths 1 to 5, which lie on both sides of the filter length. It also cycles each of the four threshold codes through a brownout and its recovery. A short count makes it cheap to interrupt power-up part-way through, and to drop the power-on flag both from the running state and from a brownout hold.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_POR_HOLD = 2'd0,
    ST_PU_WAIT  = 2'd1,
    ST_RUN      = 2'd2,
    ST_BOR_HOLD = 2'd3
  } seq_state_e;

  localparam logic KIND_POR = 1'b0;
  localparam logic KIND_BOR = 1'b1;

endpackage

// File: rtl/rstseq_filter.sv
// One comparator channel: synchroniser chain followed by a run-length filter.
module rstseq_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);

  localparam int HIST_N = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_N-1:0]      hist_q;
  logic [FILT_LEN-1:0]    window;
  logic                   sample;
  logic                   level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= raw_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign sample = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else begin
      hist_q[0] <= sample;
      for (int i = 1; i < HIST_N; i++) begin
        hist_q[i] <= hist_q[i-1];
      end
    end
  end

  // newest sample plus the FILT_LEN-1 before it
  assign window = {hist_q, sample};

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
    end else if (&window) begin
      level_q <= 1'b1;
    end else if (~|window) begin
      level_q <= 1'b0;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/rstseq_pu_timer.sv
// Power-up delay counter: counts while enabled, clears whenever not.
module rstseq_pu_timer #(
  parameter int PU_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);

  localparam int CNT_W = (PU_CYCLES > 1) ? $clog2(PU_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PU_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (!at_last) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o = run_i && at_last;

endmodule

// File: rtl/rstseq_level_reg.sv
// Brownout threshold-select register with retention and write gating.
module rstseq_level_reg #(
  parameter int                LVL_W       = 2,
  parameter logic [LVL_W-1:0]  LVL_DEFAULT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             wr_allow_i,
  input  logic             wr_en_i,
  input  logic [LVL_W-1:0] wr_data_i,
  output logic [LVL_W-1:0] level_o
);

  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      level_q <= LVL_DEFAULT;
    end else if (wr_allow_i && wr_en_i) begin
      level_q <= wr_data_i;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rstseq_pkg::*;
#(
  parameter int                 PU_CYCLES   = 65536,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 FILT_LEN    = 3,
  parameter int                 LVL_W       = 2,
  parameter int                 ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]  RESET_VEC   = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              above_por_i,
  input  logic              above_bor_i,
  input  logic              lvl_wr_en_i,
  input  logic [LVL_W-1:0]  lvl_wr_data_i,
  output logic [LVL_W-1:0]  bor_level_o,
  output logic              sys_rst_n_o,
  output logic              rst_kind_o,
  output logic              fetch_load_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);

  localparam int N_CH   = 2;
  localparam int CH_POR = 0;
  localparam int CH_BOR = 1;

  logic [N_CH-1:0] flags_raw;
  logic [N_CH-1:0] flags_ok;
  logic            por_ok;
  logic            bor_ok;
  logic            pu_done;

  seq_state_e state_q, state_d;
  logic              rst_n_q;
  logic              kind_q;
  logic              load_q;
  logic [ADDR_W-1:0] addr_q;
  logic              releasing;

  assign flags_raw[CH_POR] = above_por_i;
  assign flags_raw[CH_BOR] = above_bor_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    rstseq_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (flags_raw[ch]),
      .level_o (flags_ok[ch])
    );
  end

  assign por_ok = flags_ok[CH_POR];
  assign bor_ok = flags_ok[CH_BOR];

  rstseq_pu_timer #(
    .PU_CYCLES (PU_CYCLES)
  ) u_pu_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (state_q == ST_PU_WAIT),
    .done_o (pu_done)
  );

  // next-state logic; loss of the power-on flag dominates every state
  always_comb begin
    state_d = state_q;
    if (!por_ok) begin
      state_d = ST_POR_HOLD;
    end else begin
      unique case (state_q)
        ST_POR_HOLD: if (bor_ok) state_d = ST_PU_WAIT;
        ST_PU_WAIT: begin
          if (!bor_ok)      state_d = ST_POR_HOLD;
          else if (pu_done) state_d = ST_RUN;
        end
        ST_RUN:      if (!bor_ok) state_d = ST_BOR_HOLD;
        ST_BOR_HOLD: if (bor_ok)  state_d = ST_RUN;
        default:     state_d = ST_POR_HOLD;
      endcase
    end
  end

  assign releasing = (state_d == ST_RUN) && (state_q != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_POR_HOLD;
      rst_n_q <= 1'b0;
      kind_q  <= KIND_POR;
      load_q  <= 1'b0;
      addr_q  <= RESET_VEC;
    end else begin
      state_q <= state_d;
      rst_n_q <= (state_d == ST_RUN);
      load_q  <= releasing;
      if (releasing) begin
        addr_q <= RESET_VEC;
      end
      if (state_d == ST_POR_HOLD) begin
        kind_q <= KIND_POR;
      end else if (state_q == ST_RUN && state_d == ST_BOR_HOLD) begin
        kind_q <= KIND_BOR;
      end
    end
  end

  rstseq_level_reg #(
    .LVL_W       (LVL_W),
    .LVL_DEFAULT ('0)
  ) u_level (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (state_d == ST_POR_HOLD),
    .wr_allow_i (state_q == ST_RUN),
    .wr_en_i    (lvl_wr_en_i),
    .wr_data_i  (lvl_wr_data_i),
    .level_o    (bor_level_o)
  );

  assign sys_rst_n_o  = rst_n_q;
  assign rst_kind_o   = kind_q;
  assign fetch_load_o = load_q;
  assign fetch_addr_o = addr_q;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
  import rstseq_pkg::*;
#(
  parameter int                LVL_W     = 2,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'h8000
) (
  input logic              clk,
  input logic              rst,
  input logic              por_ok,
  input logic              bor_ok,
  input logic              pu_done,
  input seq_state_e        state_q,
  input logic              sys_rst_n_o,
  input logic              rst_kind_o,
  input logic [LVL_W-1:0]  bor_level_o,
  input logic              fetch_load_o,
  input logic [ADDR_W-1:0] fetch_addr_o
);

  // R2
  bor_low_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !bor_ok |=> !sys_rst_n_o);

  // R3
  por_release_after_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sys_rst_n_o) && rst_kind_o == KIND_POR) |-> $past(pu_done));

  // R4
  bor_release_direct_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sys_rst_n_o) && rst_kind_o == KIND_BOR) |-> $past(state_q) == ST_BOR_HOLD);

  // R5
  por_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !por_ok |=> (!sys_rst_n_o && rst_kind_o == KIND_POR));

  // R5
  por_level_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_n_o && rst_kind_o == KIND_POR) |-> bor_level_o == '0);

  // R7
  level_frozen_in_bor_chk: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_n_o && rst_kind_o == KIND_BOR && por_ok) |=> $stable(bor_level_o));

  // R8
  load_only_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_load_o |-> (sys_rst_n_o && fetch_addr_o == RESET_VEC));

  // R8
  release_has_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n_o) |-> fetch_load_o);

  // R8
  load_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_load_o |=> !fetch_load_o);

endmodule

bind supply_reset_seq rstseq_chk #(
  .LVL_W     (LVL_W),
  .ADDR_W    (ADDR_W),
  .RESET_VEC (RESET_VEC)
) u_rstseq_chk (
  .clk          (clk),
  .rst          (rst),
  .por_ok       (por_ok),
  .bor_ok       (bor_ok),
  .pu_done      (pu_done),
  .state_q      (state_q),
  .sys_rst_n_o  (sys_rst_n_o),
  .rst_kind_o   (rst_kind_o),
  .bor_level_o  (bor_level_o),
  .fetch_load_o (fetch_load_o),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/test_supply_reset_seq.sv
`timescale 1ns/1ps
module test_supply_reset_seq;

  localparam int PU    = 16;
  localparam int SYNC  = 2;
  localparam int FL    = 3;
  localparam int LVL_W = 2;
  localparam int AW    = 16;
  localparam int LAT   = SYNC + FL + 1;   // flag edge to reset-output edge
  localparam int VEC   = 32'h8000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             above_por = 1'b0;
  logic             above_bor = 1'b0;
  logic             wr_en = 1'b0;
  logic [LVL_W-1:0] wr_data = '0;
  logic [LVL_W-1:0] level;
  logic             rst_n;
  logic             kind;
  logic             load;
  logic [AW-1:0]    addr;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  supply_reset_seq #(
    .PU_CYCLES   (PU),
    .SYNC_STAGES (SYNC),
    .FILT_LEN    (FL),
    .LVL_W       (LVL_W),
    .ADDR_W      (AW),
    .RESET_VEC   (16'h8000)
  ) i_supply_reset_seq (
    .clk           (clk),
    .rst           (rst),
    .above_por_i   (above_por),
    .above_bor_i   (above_bor),
    .lvl_wr_en_i   (wr_en),
    .lvl_wr_data_i (wr_data),
    .bor_level_o   (level),
    .sys_rst_n_o   (rst_n),
    .rst_kind_o    (kind),
    .fetch_load_o  (load),
    .fetch_addr_o  (addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_level(input int v);
    wr_en   = 1'b1;
    wr_data = LVL_W'(v);
    step(1);
    wr_en   = 1'b0;
  endtask

  // inputs changed at the current negedge; release expected after 'edges' edges
  task automatic expect_release(input string tag, input int edges, input int exp_kind);
    step(edges - 1);
    chk({tag, " still held"}, 32'(rst_n), 0);
    step(1);
    chk({tag, " released"}, 32'(rst_n), 1);
    chk({tag, " R9 kind"}, 32'(kind), exp_kind);
    chk({tag, " R8 load"}, 32'(load), 1);
    chk({tag, " R8 addr"}, 32'(addr), VEC);
    step(1);
    chk({tag, " R8 load drop"}, 32'(load), 0);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL WDOG: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rst_n", 32'(rst_n), 0);
    chk("R1 kind", 32'(kind), 0);
    chk("R1 level", 32'(level), 0);
    chk("R1 load", 32'(load), 0);
    chk("R1 addr", 32'(addr), VEC);

    // R3 power-up release with full count
    above_por = 1'b1;
    above_bor = 1'b1;
    expect_release("R3 first power-up", LAT + PU, 0);

    // R7 writes in RUN, all codes
    for (int v = 0; v < 4; v++) begin
      wr_level(v);
      chk("R7 write in run", 32'(level), v);
    end

    // R6/R4/R12/R2 brownout cycle for every threshold code
    for (int v = 0; v < 4; v++) begin
      wr_level(v);
      above_bor = 1'b0;
      step(LAT - 1);
      chk("R12 not yet low", 32'(rst_n), 1);
      step(1);
      chk("R12 low on brownout", 32'(rst_n), 0);
      chk("R9 kind brownout", 32'(kind), 1);
      step(5);
      chk("R2 held", 32'(rst_n), 0);
      wr_level(3 - v);
      chk("R7 write ignored in hold", 32'(level), v);
      above_bor = 1'b1;
      expect_release("R4 brownout recovery", LAT, 1);
      chk("R6 level retained", 32'(level), v);
    end

    // R10 glitch width sweep
    for (int w = 1; w <= 5; w++) begin
      bit saw_low;
      saw_low = 1'b0;
      above_bor = 1'b0;
      for (int i = 0; i < w; i++) begin
        step(1);
        if (!rst_n) saw_low = 1'b1;
      end
      above_bor = 1'b1;
      for (int i = 0; i < LAT + 2; i++) begin
        step(1);
        if (!rst_n) saw_low = 1'b1;
      end
      chk("R10 glitch width", 32'(saw_low), (w >= FL) ? 1 : 0);
      step(LAT + 2);
      chk("R10 recovered", 32'(rst_n), 1);
    end

    // R5 power-on loss from RUN
    wr_level(3);
    above_por = 1'b0;
    above_bor = 1'b0;
    step(LAT - 1);
    chk("R5 not yet low", 32'(rst_n), 1);
    step(1);
    chk("R5 low", 32'(rst_n), 0);
    chk("R5 kind por", 32'(kind), 0);
    chk("R5 level cleared", 32'(level), 0);
    wr_level(1);
    chk("R7 write ignored in por", 32'(level), 0);
    step(3);

    // R11 brownout during power-up count restarts it
    above_por = 1'b1;
    above_bor = 1'b1;
    step(LAT + 5);
    chk("R11 counting", 32'(rst_n), 0);
    above_bor = 1'b0;
    step(4);
    above_bor = 1'b1;
    expect_release("R11 restarted count", LAT + PU, 0);

    // R5 power-on loss from a brownout hold
    wr_level(2);
    above_bor = 1'b0;
    step(LAT + 2);
    chk("R9 kind in hold", 32'(kind), 1);
    chk("R6 level in hold", 32'(level), 2);
    above_por = 1'b0;
    step(LAT);
    chk("R5 kind after por", 32'(kind), 0);
    chk("R5 level after por", 32'(level), 0);
    above_por = 1'b1;
    above_bor = 1'b1;
    expect_release("R3 power-up after hold", LAT + PU, 0);

    finished = 1'b1;
    summary();
  end

endmodule